// File: doc/BRIEF.md
# Dithered Third-Order Cascaded Delta-Sigma Modulator

This block steers the feedback divider of a fractional-N synthesizer. On every enabled reference clock it adds a fractional word to a first accumulator whose wrap point is a programmable modulus. That modulus need not be a power of two, so ratios such as 1/3 or 45/123 come out exactly. The part of the sum left after the wrap feeds a chain of two power-of-two accumulators. The carries of all three stages are merged by a difference network into one small signed correction. Over time this correction averages to `frac_i / m1_i`, and its error is pushed towards high frequencies.

Only the second and third stages receive dither. It is one pseudorandom bit per clock from a 7-bit shift register with feedback polynomial x^7 + x^6 + 1. This breaks up idle tones without disturbing the exact first-stage ratio. The first stage is wider (`W1`) than the dithered stages (`W2`). Its residue is cut to its upper `W2` bits before it enters stage two.

A two-state controller follows the enable. `ST_IDLE` is entered from reset, or from `ST_RUN` on any edge where `en_i` is low. In this state the output is zero and every register holds. `ST_RUN` is entered from either state on any edge where `en_i` is high. In this state the registered correction is driven out.

Top module: `mash_dsm`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `y_o` is 0. Reset clears all accumulators and carry delays and loads the dither register with a nonzero seed.
- R2: The first-stage residue stays below `m1_i` whenever `2 <= m1_i` and `frac_i < m1_i`. A carry of 1 is produced exactly when residue plus fraction reaches `m1_i`.
- R3: Counting from reset, the sum of `y_o` over N enabled cycles lies in [floor(N·frac_i/m1_i) − 1, floor(N·frac_i/m1_i) + 2].
- R4: `y_o` is 4-bit two's complement and always lies in −3 to +4.
- R5: An edge with `en_i` low moves to `ST_IDLE`, forces `y_o` to 0 and freezes all state. After `en_i` returns high, the sequence resumes, so the bound of R3 holds over the enabled cycles on both sides of the pause.
- R6: The dither register never holds zero after reset and advances only on enabled edges.
- R7: Dither reaches only stages two and three. With `frac_i = 0` the first stage never carries, the window sum of R3 stays within −1 to +2, and `y_o` is still nonzero on some cycles.
- R8: `y_o` takes a new value on the first clock edge at which `en_i` is high. Before that edge it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the modulator on this edge |
| m1_i | input | W1 | First-stage modulus, at least 2 |
| frac_i | input | W1 | Fractional word, below `m1_i` |
| y_o | output | 4 | Signed divide-ratio correction |

## Verification
The cancellation network is the hardest part to observe from the ports. A wrong sign or a stale delay in the second- or third-stage difference terms does not show as an illegal value. It only shifts the running sum by a few counts after many cycles. The stimulus therefore runs each operating point for hundreds to thousands of cycles from a clean reset, with window lengths that are exact multiples of the modulus. At those lengths the ideal carry total is an integer known in advance, and the sum must sit inside a three-count band around it. One run is split by a pause to show that the frozen state rejoins without drift. A zero-fraction run shows that the dither alone moves the output while the sum stays bounded.

// File: rtl/mash_pkg.sv
package mash_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mash_state_e;

    localparam int DITH_W   = 7;
    localparam int OUT_W    = 4;
    localparam int N_P2     = 2;
endpackage

// File: rtl/mash_lfsr.sv
module mash_lfsr
    import mash_pkg::*;
#(
    parameter logic [DITH_W-1:0] SEED = 7'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [DITH_W-1:0] q
);
    logic fb;

    assign fb = q[DITH_W-1] ^ q[DITH_W-2];

    always_ff @(posedge clk) begin
        if (rst)
            q <= SEED;
        else if (adv)
            q <= {q[DITH_W-2:0], fb};
    end

    a_r6_nonzero: assert property (@(posedge clk) disable iff (rst)
        q != '0);
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(q));
endmodule

// File: rtl/mash_mod_acc.sv
module mash_mod_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] f_i,
    output logic         carry_o,
    output logic [W-1:0] resid_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    logic [W:0]   wrapped;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, f_i};
        wrapped = sum - {1'b0, m_i};
        if (sum >= {1'b0, m_i}) begin
            carry_o = 1'b1;
            resid_o = wrapped[W-1:0];
        end else begin
            carry_o = 1'b0;
            resid_o = sum[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (adv)
            acc_q <= resid_o;
    end

    a_r2_below_mod: assert property (@(posedge clk) disable iff (rst)
        (adv && m_i >= 2 && f_i < m_i && acc_q < m_i) |=> acc_q < $past(m_i));
endmodule

// File: rtl/mash_p2_acc.sv
module mash_p2_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] in_i,
    input  logic         dith_i,
    output logic         carry_o,
    output logic [W-1:0] resid_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, in_i} + {{W{1'b0}}, dith_i};
    assign carry_o = sum[W];
    assign resid_o = sum[W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (adv)
            acc_q <= resid_o;
    end
endmodule

// File: rtl/mash_dsm.sv
module mash_dsm
    import mash_pkg::*;
#(
    parameter int                W1   = 12,
    parameter int                W2   = 8,
    parameter logic [DITH_W-1:0] SEED = 7'h5A
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic [W1-1:0]           m1_i,
    input  logic [W1-1:0]           frac_i,
    output logic signed [OUT_W-1:0] y_o
);
    localparam int TOP1 = W1 - 1;

    mash_state_e       st_q;
    logic [DITH_W-1:0] lfsr_q;
    logic              dith;
    logic              c1;
    logic [W1-1:0]     s1_res;
    logic [W2-1:0]     p2_in  [N_P2];
    logic [W2-1:0]     p2_res [N_P2];
    logic              p2_c   [N_P2];
    logic              c2_d, c3_d1, c3_d2;
    logic [OUT_W-1:0]  y_next;
    logic [OUT_W-1:0]  y_q;

    mash_lfsr #(.SEED(SEED)) u_dith (
        .clk (clk),
        .rst (rst),
        .adv (en_i),
        .q   (lfsr_q)
    );
    assign dith = lfsr_q[0];

    mash_mod_acc #(.W(W1)) u_s1 (
        .clk     (clk),
        .rst     (rst),
        .adv     (en_i),
        .m_i     (m1_i),
        .f_i     (frac_i),
        .carry_o (c1),
        .resid_o (s1_res)
    );

    assign p2_in[0] = s1_res[TOP1 -: W2];

    for (genvar g = 0; g < N_P2; g++) begin : g_p2
        if (g > 0) begin : g_link
            assign p2_in[g] = p2_res[g-1];
        end
        mash_p2_acc #(.W(W2)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .adv     (en_i),
            .in_i    (p2_in[g]),
            .dith_i  (dith),
            .carry_o (p2_c[g]),
            .resid_o (p2_res[g])
        );
    end

    always_comb begin
        y_next = {3'b000, c1}
               + {3'b000, p2_c[0]} - {3'b000, c2_d}
               + {3'b000, p2_c[1]} - {2'b00, c3_d1, 1'b0} + {3'b000, c3_d2};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
            y_q   <= '0;
        end else if (en_i) begin
            c2_d  <= p2_c[0];
            c3_d1 <= p2_c[1];
            c3_d2 <= c3_d1;
            y_q   <= y_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_IDLE;
        else if (en_i)
            st_q <= ST_RUN;
        else
            st_q <= ST_IDLE;
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: y_o = '0;
            ST_RUN:  y_o = $signed(y_q);
            default: y_o = '0;
        endcase
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> y_o == 0);
    a_r4_range: assert property (@(posedge clk) disable iff (rst)
        ($signed(y_o) >= -4'sd3) && ($signed(y_o) <= 4'sd4));
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> y_o == 0);
    a_r7_no_frac_no_carry: assert property (@(posedge clk) disable iff (rst)
        (en_i && frac_i == 0 && m1_i >= 2) |-> !c1);
endmodule

// File: tb/mash_dsm_test.sv
module mash_dsm_test;
    localparam int W1 = 12;
    localparam int NV = 8;
    localparam int VM1 [NV] = '{3, 10, 1000, 1000, 4095, 7, 2, 123};
    localparam int VFR [NV] = '{1, 3, 1, 999, 2048, 0, 1, 45};
    localparam int VLEN[NV] = '{300, 1000, 3000, 2000, 4095, 700, 200, 1230};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en_i = 1'b0;
    logic [W1-1:0]     m1_i = 12'd3;
    logic [W1-1:0]     frac_i = '0;
    logic signed [3:0] y_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mash_dsm uut (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .m1_i   (m1_i),
        .frac_i (frac_i),
        .y_o    (y_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        en_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(y_o == 0, "R1 reset output", y_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(y_o == 0, "R1 first cycle after reset", y_o, 0);
    endtask

    task automatic run(input int n, inout longint acc, inout int nz, inout bit range_ok);
        en_i = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            acc += y_o;
            if (y_o != 0) nz++;
            if (y_o < -3 || y_o > 4) range_ok = 1'b0;
        end
        en_i = 1'b0;
    endtask

    task automatic check_mean(input string req, input longint acc, input longint n,
                              input longint m, input longint f);
        longint ideal;
        ideal = (n * f) / m;
        check(acc >= ideal - 1 && acc <= ideal + 2, req, acc, ideal);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        longint acc;
        int     nz;
        bit     rok;
        bit     idle_ok;

        // Vector table: one operating point per entry (R2, R3, R4, R7)
        for (int v = 0; v < NV; v++) begin
            m1_i   = VM1[v][W1-1:0];
            frac_i = VFR[v][W1-1:0];
            do_reset();
            acc = 0; nz = 0; rok = 1'b1;
            run(VLEN[v], acc, nz, rok);
            check(rok, "R4 output range", acc, 0);
            check_mean("R3 R2 long-run mean", acc, VLEN[v], VM1[v], VFR[v]);
            if (VFR[v] == 0) begin
                check(nz > 0, "R7 dither moves output", nz, 1);
                check(acc >= -1 && acc <= 2, "R7 zero-fraction sum", acc, 0);
            end
        end

        // R8: first enabled edge updates the output, value 0 before it
        m1_i = 12'd2; frac_i = 12'd1;
        do_reset();
        @(negedge clk);
        check(y_o == 0, "R8 before enable", y_o, 0);
        en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        en_i = 1'b0;
        // stage one with 1/2 from zero: no carry on first step; output then only
        // carries dither terms, so it lies in -3..4; the idle edge must clear it
        check(y_o >= -3 && y_o <= 4, "R8 first enabled value", y_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(y_o == 0, "R5 idle after one step", y_o, 0);

        // R5: pause in the middle of a run
        m1_i = 12'd10; frac_i = 12'd3;
        do_reset();
        acc = 0; nz = 0; rok = 1'b1;
        run(100, acc, nz, rok);
        idle_ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (y_o != 0) idle_ok = 1'b0;
        end
        check(idle_ok, "R5 output zero while paused", y_o, 0);
        run(100, acc, nz, rok);
        check_mean("R5 R6 mean across pause", acc, 200, 10, 3);

        // R1: reset in the middle of a run
        m1_i = 12'd7; frac_i = 12'd5;
        en_i = 1'b1;
        repeat (13) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(y_o == 0, "R1 mid-run reset", y_o, 0);
        en_i = 1'b0;
        rst  = 1'b0;
        acc = 0; nz = 0; rok = 1'b1;
        run(700, acc, nz, rok);
        check_mean("R1 R3 restart after reset", acc, 700, 7, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule